// File: doc/BRIEF.md
# Ternary CAM Lookup Engine

This block is a scaled-down ternary content-addressable search engine. Every location holds a data word and a mask word of the same width. A mask bit of 1 makes that stored bit don't-care, so each stored bit can act as 0, 1 or X. A host reaches the block through a strobed command port and one shared bidirectional word bus. The bus carries addresses, write data, read-back data and search keys.

A lookup compares a key against every location at once. Bits set in one of four global mask registers are left out of the compare, and the command picks which register applies. A lookup can be one, two or four words wide. In a wider search the key words arrive on consecutive clocks, and only width-aligned groups of consecutive locations take part. The lowest matching location wins. Its index is reported on a separate output path together with a hit flag. A match-in/match-out pair lets several engines be chained: a hit upstream suppresses this engine's result.

Top module: `tcam_engine`

## Requirements
- R1: While reset is active and in the first cycle after it, `res_valid`, `res_hit`, `match_out` and `res_index` are 0 and the bus is not driven. Reset clears the enable bit, sets the width code to 0, and clears every global mask, data word and mask word.
- R2: Command opcodes are 00 no-op, 01 read, 10 write and 11 lookup. Targets are 00 data array, 01 mask array and 10 registers. A command is accepted when `req_strobe` is high while the engine is idle, and the address is taken from bus bits [7:0]. A write takes its data from the bus in the next clock. A read drives the addressed word onto the bus during exactly the one clock after the strobe.
- R3: Register addresses 0..3 hold global masks 0..3. Address 4 is the configuration word: bit 0 is enable and bits [2:1] are the width code (0 means one word, 1 means two, 2 or 3 means four). Reads of other register addresses return 0. Every register reads back what was written.
- R4: A stored bit matches a key bit when the two are equal or when the stored mask bit is 1. A location matches only if all of its bits match.
- R5: During a lookup, key bits at positions where the selected global mask (`cmd_gsel` at the strobe) is 1 never cause a mismatch.
- R6: When several locations match, `res_index` is the lowest matching index.
- R7: The result of a lookup appears with `res_valid` high for one clock, two clocks after the clock that carried the last key word. On a miss, `res_valid` is 1 with `res_hit` and `res_index` 0.
- R8: In one-word mode a new lookup can be strobed every clock, and each result follows its own strobe by two clocks.
- R9: In two-word mode the key words arrive on two consecutive clocks. The candidates are even locations b whose words b and b+1 match key words 0 and 1, and the reported index is b.
- R10: In four-word mode four key words arrive on consecutive clocks. The candidates are locations b that are multiples of 4 whose words b..b+3 all match, and the reported index is b.
- R11: In the result clock, `match_in` high forces `res_hit` and `res_index` to 0. In the result clock, `match_out` is high when this engine hit or `match_in` is high, and it is 0 in all other clocks.
- R12: A lookup strobed while the enable bit is 0 is ignored and produces no `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_strobe | input | 1 | Starts a command |
| cmd_op | input | 2 | Operation code |
| cmd_gsel | input | 2 | Global mask select for a lookup |
| cmd_tgt | input | 2 | Target of a read or write |
| req_bus | inout | 72 | Shared address/data/key bus |
| match_in | input | 1 | Upstream engine hit |
| res_valid | output | 1 | Lookup result clock |
| res_hit | output | 1 | This engine reports a hit |
| res_index | output | 6 | Index of the winning location |
| match_out | output | 1 | Hit here or upstream, to the downstream engine |

## Verification
Assertions check several properties on every clock. A read drives the bus for exactly one clock after it is accepted. A one-word lookup yields `res_valid` two clocks later. No result appears unless the engine was enabled when the lookup began. A reported index is always aligned to the configured width. The bench scenarios cover what assertions cannot see, because the expected values depend on the stored contents. These are the correctness of the ternary compare, the effect of global masking, the choice of the lowest match, the matching of wide groups across words, and read-back values. The bench sweeps every key index against every global mask with back-to-back lookups, and then sweeps the two-word and four-word modes.

// File: rtl/tcam_pkg.sv
`timescale 1ns/1ps
package tcam_pkg;
    typedef enum logic [1:0] {
        OP_NOP    = 2'd0,
        OP_READ   = 2'd1,
        OP_WRITE  = 2'd2,
        OP_LOOKUP = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        TG_DATA = 2'd0,
        TG_MASK = 2'd1,
        TG_REG  = 2'd2,
        TG_NONE = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WDATA = 2'd1,
        ST_LMORE = 2'd2
    } state_e;

    // configuration word: bit0 enable, bits[2:1] width code
    typedef struct packed {
        logic [1:0] wcode;
        logic       en;
    } cfg_t;

    localparam int ADDR_W = 8;

    // index of the last key word for a width code
    function automatic logic [1:0] last_word(input logic [1:0] wcode);
        case (wcode)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/tcam_array.sv
`timescale 1ns/1ps
module tcam_array #(
    parameter int ENTRIES = 64,
    parameter int W       = 72
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic                       wr_is_mask,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic [W-1:0]               wr_word,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    output logic [W-1:0]               rd_data,
    output logic [W-1:0]               rd_mask,
    input  logic [W-1:0]               key,
    input  logic [W-1:0]               gmask,
    output logic [ENTRIES-1:0]         word_hit
);
    localparam int IW = $clog2(ENTRIES);

    logic [W-1:0] data_q [ENTRIES];
    logic [W-1:0] mask_q [ENTRIES];

    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (rst) begin
                data_q[e] <= '0;
                mask_q[e] <= '0;
            end else if (wr_en && wr_idx == IW'(e)) begin
                if (wr_is_mask) mask_q[e] <= wr_word;
                else            data_q[e] <= wr_word;
            end
        end
    end

    assign rd_data = data_q[rd_idx];
    assign rd_mask = mask_q[rd_idx];

    // per-location ternary compare; a 1 in either mask removes the bit
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign word_hit[e] = ~|((key ^ data_q[e]) & ~(mask_q[e] | gmask));
    end
endmodule

// File: rtl/tcam_prio_enc.sv
`timescale 1ns/1ps
module tcam_prio_enc #(
    parameter int ENTRIES = 64
) (
    input  logic [ENTRIES-1:0]         part,
    input  logic [1:0]                 wcode,
    output logic                       hit,
    output logic [$clog2(ENTRIES)-1:0] idx
);
    localparam int IW = $clog2(ENTRIES);

    logic [ENTRIES-1:0] cand;

    // ENTRIES is a multiple of 4
    for (genvar e = 0; e < ENTRIES; e++) begin : g_grp
        logic pair_ok, quad_ok;
        if (e % 2 == 0) begin : g_pair
            assign pair_ok = &part[e+1:e];
        end else begin : g_nopair
            assign pair_ok = 1'b0;
        end
        if (e % 4 == 0) begin : g_quad
            assign quad_ok = &part[e+3:e];
        end else begin : g_noquad
            assign quad_ok = 1'b0;
        end
        assign cand[e] = (wcode == 2'd0) ? part[e] :
                         (wcode == 2'd1) ? pair_ok : quad_ok;
    end

    always_comb begin
        hit = |cand;
        idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (cand[e]) idx = IW'(e);
        end
    end
endmodule

// File: rtl/tcam_engine.sv
`timescale 1ns/1ps
module tcam_engine
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int W       = 72,
    parameter int GMASKS  = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_strobe,
    input  logic [1:0]                 cmd_op,
    input  logic [$clog2(GMASKS)-1:0]  cmd_gsel,
    input  logic [1:0]                 cmd_tgt,
    inout  wire  [W-1:0]               req_bus,
    input  logic                       match_in,
    output logic                       res_valid,
    output logic                       res_hit,
    output logic [$clog2(ENTRIES)-1:0] res_index,
    output logic                       match_out
);
    localparam int IW  = $clog2(ENTRIES);
    localparam int GSW = $clog2(GMASKS);

    state_e             state_q;
    tgt_e               wtgt_q;
    logic [ADDR_W-1:0]  addr_q;
    cfg_t               cfg_q;
    logic [W-1:0]       gm_q [GMASKS];
    logic [GSW-1:0]     gsel_q;
    logic [1:0]         kcnt_q;
    logic [ENTRIES-1:0] part_q;
    logic               last_q;
    logic               res_valid_q, res_hit_q;
    logic [IW-1:0]      res_idx_q;
    logic               rd_oe_q;
    logic [W-1:0]       rd_q;

    logic [W-1:0]       bus_in;
    logic [ADDR_W-1:0]  bus_addr;
    logic               accept, lk_start, lk_word, lk_last;
    logic [GSW-1:0]     cur_gsel;
    logic [1:0]         cur_k, lastk;
    logic [W-1:0]       arr_rd_data, arr_rd_mask, reg_rd, rd_val;
    logic [ENTRIES-1:0] word_hit;
    logic               enc_hit;
    logic [IW-1:0]      enc_idx;
    logic               cfg_en;
    logic [1:0]         cfg_wcode;

    assign bus_in    = req_bus;
    assign bus_addr  = bus_in[ADDR_W-1:0];
    assign cfg_en    = cfg_q.en;
    assign cfg_wcode = cfg_q.wcode;
    assign lastk     = last_word(cfg_q.wcode);
    assign accept    = req_strobe && (state_q == ST_IDLE);
    assign lk_start  = accept && (op_e'(cmd_op) == OP_LOOKUP) && cfg_q.en;
    assign lk_word   = lk_start || (state_q == ST_LMORE);
    assign cur_gsel  = lk_start ? cmd_gsel : gsel_q;
    assign cur_k     = lk_start ? 2'd0 : kcnt_q;
    assign lk_last   = lk_word && (cur_k == lastk);

    tcam_array #(.ENTRIES(ENTRIES), .W(W)) u_array (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (state_q == ST_WDATA && (wtgt_q == TG_DATA || wtgt_q == TG_MASK)),
        .wr_is_mask (wtgt_q == TG_MASK),
        .wr_idx     (addr_q[IW-1:0]),
        .wr_word    (bus_in),
        .rd_idx     (bus_addr[IW-1:0]),
        .rd_data    (arr_rd_data),
        .rd_mask    (arr_rd_mask),
        .key        (bus_in),
        .gmask      (gm_q[cur_gsel]),
        .word_hit   (word_hit)
    );

    tcam_prio_enc #(.ENTRIES(ENTRIES)) u_enc (
        .part  (part_q),
        .wcode (cfg_q.wcode),
        .hit   (enc_hit),
        .idx   (enc_idx)
    );

    always_comb begin
        if (bus_addr < ADDR_W'(GMASKS))       reg_rd = gm_q[bus_addr[GSW-1:0]];
        else if (bus_addr == ADDR_W'(GMASKS)) reg_rd = W'(cfg_q);
        else                                  reg_rd = '0;
        case (tgt_e'(cmd_tgt))
            TG_DATA: rd_val = arr_rd_data;
            TG_MASK: rd_val = arr_rd_mask;
            TG_REG:  rd_val = reg_rd;
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            wtgt_q      <= TG_NONE;
            addr_q      <= '0;
            cfg_q       <= '0;
            gsel_q      <= '0;
            kcnt_q      <= '0;
            part_q      <= '0;
            last_q      <= 1'b0;
            res_valid_q <= 1'b0;
            res_hit_q   <= 1'b0;
            res_idx_q   <= '0;
            rd_oe_q     <= 1'b0;
            rd_q        <= '0;
            for (int g = 0; g < GMASKS; g++) gm_q[g] <= '0;
        end else begin
            rd_oe_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    if (op_e'(cmd_op) == OP_READ) begin
                        rd_oe_q <= 1'b1;
                        rd_q    <= rd_val;
                    end else if (op_e'(cmd_op) == OP_WRITE) begin
                        state_q <= ST_WDATA;
                        wtgt_q  <= tgt_e'(cmd_tgt);
                        addr_q  <= bus_addr;
                    end else if (lk_start) begin
                        gsel_q <= cmd_gsel;
                        kcnt_q <= 2'd1;
                        if (lastk != 2'd0) state_q <= ST_LMORE;
                    end
                end
                ST_WDATA: begin
                    state_q <= ST_IDLE;
                    if (wtgt_q == TG_REG) begin
                        if (addr_q < ADDR_W'(GMASKS))       gm_q[addr_q[GSW-1:0]] <= bus_in;
                        else if (addr_q == ADDR_W'(GMASKS)) cfg_q <= cfg_t'(bus_in[2:0]);
                    end
                end
                ST_LMORE: begin
                    kcnt_q <= kcnt_q + 2'd1;
                    if (kcnt_q == lastk) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
            // word k of a wide key scores the locations at position k of each group
            for (int e = 0; e < ENTRIES; e++) begin
                if (lk_word && ((2'(e) & lastk) == cur_k)) part_q[e] <= word_hit[e];
            end
            last_q      <= lk_last;
            res_valid_q <= last_q;
            if (last_q) begin
                res_hit_q <= enc_hit;
                res_idx_q <= enc_idx;
            end
        end
    end

    assign req_bus   = rd_oe_q ? rd_q : 'z;
    assign res_valid = res_valid_q;
    assign res_hit   = res_valid_q && res_hit_q && !match_in;
    assign res_index = res_hit ? res_idx_q : '0;
    assign match_out = res_valid_q && (res_hit_q || match_in);
endmodule

// File: rtl/tcam_engine_chk.sv
`timescale 1ns/1ps
module tcam_engine_chk #(
    parameter int IW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          req_strobe,
    input logic [1:0]    cmd_op,
    input logic          res_valid,
    input logic          res_hit,
    input logic [IW-1:0] res_index,
    input logic          rd_oe_q,
    input logic [1:0]    state_q,
    input logic          cfg_en,
    input logic [1:0]    cfg_wcode
);
    logic [1:0] align_m;
    assign align_m = (cfg_wcode == 2'd0) ? 2'b00 : (cfg_wcode == 2'd1) ? 2'b01 : 2'b11;

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && !rd_oe_q)); // R1

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (req_strobe && cmd_op == 2'd1 && state_q == 2'd0) |=> rd_oe_q); // R2

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_oe_q |=> !rd_oe_q); // R2

    AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (req_strobe && cmd_op == 2'd3 && state_q == 2'd0 && cfg_en && cfg_wcode == 2'd0)
        |=> ##1 res_valid); // R7

    AST_INDEX_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> ((res_index[1:0] & align_m) == 2'b00)); // R9

    AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(cfg_en, 2)); // R12
endmodule

bind tcam_engine tcam_engine_chk #(.IW(IW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_strobe (req_strobe),
    .cmd_op     (cmd_op),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_index  (res_index),
    .rd_oe_q    (rd_oe_q),
    .state_q    (state_q),
    .cfg_en     (cfg_en),
    .cfg_wcode  (cfg_wcode)
);

// File: tb/tcam_engine_test.sv
`timescale 1ns/1ps
module tcam_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_strobe = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [1:0]  cmd_gsel = 2'd0;
    logic [1:0]  cmd_tgt = 2'd0;
    logic [71:0] tb_bus = '0;
    logic        tb_oe = 1'b0;
    wire  [71:0] bus;
    logic        match_in = 1'b0;
    logic        res_valid, res_hit, match_out;
    logic [5:0]  res_index;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [71:0] m_data [64];
    logic [71:0] m_mask [64];
    logic [71:0] m_gm [4];
    logic        p_hit [64];
    logic [5:0]  p_idx [64];

    assign bus = tb_oe ? tb_bus : 'z;

    always #10 clk = ~clk;

    tcam_engine uut (
        .clk(clk), .rst(rst), .req_strobe(req_strobe), .cmd_op(cmd_op),
        .cmd_gsel(cmd_gsel), .cmd_tgt(cmd_tgt), .req_bus(bus),
        .match_in(match_in), .res_valid(res_valid), .res_hit(res_hit),
        .res_index(res_index), .match_out(match_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [71:0] mk_key(input logic [7:0] top, input int k);
        return {top, 58'h0, 6'(k)};
    endfunction

    function automatic bit ref_hit(input int e, input logic [71:0] key, input int gs);
        return ((key ^ m_data[e]) & ~(m_mask[e] | m_gm[gs])) == 72'h0;
    endfunction

    task automatic ref_lookup(input logic [3:0][71:0] keys, input int n, input int gs,
                              output logic hit, output logic [5:0] idx);
        hit = 1'b0;
        idx = '0;
        for (int b = 0; b < 64; b += n) begin
            bit all = 1;
            for (int j = 0; j < n; j++) if (!ref_hit(b + j, keys[j], gs)) all = 0;
            if (all && !hit) begin
                hit = 1'b1;
                idx = 6'(b);
            end
        end
    endtask

    task automatic idle_inputs();
        req_strobe = 1'b0;
        cmd_op     = 2'd0;
        tb_oe      = 1'b0;
    endtask

    task automatic wr(input logic [1:0] tgt, input int addr, input logic [71:0] val);
        @(posedge clk); #1;
        req_strobe = 1'b1; cmd_op = 2'd2; cmd_tgt = tgt; tb_oe = 1'b1; tb_bus = 72'(addr);
        @(posedge clk); #1;
        req_strobe = 1'b0; cmd_op = 2'd0; tb_bus = val;
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic rd_chk(input logic [1:0] tgt, input int addr, input logic [71:0] exp,
                          input string req);
        @(posedge clk); #1;
        req_strobe = 1'b1; cmd_op = 2'd1; cmd_tgt = tgt; tb_oe = 1'b1; tb_bus = 72'(addr);
        @(posedge clk); #1;
        idle_inputs();
        @(negedge clk);
        chk(bus === exp, req, "read-back", bus, exp);
    endtask

    // drives n key words, then samples the result clock
    task automatic lookup(input logic [3:0][71:0] keys, input int n, input int gs,
                          input bit exp_valid, input string req);
        logic eh;
        logic [5:0] ei;
        ref_lookup(keys, n, gs, eh, ei);
        for (int j = 0; j < n; j++) begin
            @(posedge clk); #1;
            req_strobe = (j == 0); cmd_op = (j == 0) ? 2'd3 : 2'd0;
            cmd_gsel = 2'(gs); tb_oe = 1'b1; tb_bus = keys[j];
        end
        @(posedge clk); #1;
        idle_inputs();
        @(posedge clk);
        @(negedge clk);
        chk(res_valid == exp_valid, req, "res_valid", 72'(res_valid), 72'(exp_valid));
        if (exp_valid) begin
            chk(res_hit == (eh && !match_in), req, "res_hit", 72'(res_hit), 72'(eh && !match_in));
            chk(res_index == ((eh && !match_in) ? ei : 6'd0), req, "res_index",
                72'(res_index), 72'((eh && !match_in) ? ei : 6'd0));
            chk(match_out == (eh || match_in), req, "match_out", 72'(match_out), 72'(eh || match_in));
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0][71:0] keys;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs right after reset
        chk(res_valid == 0 && res_hit == 0 && match_out == 0 && res_index == 0, "R1",
            "outputs after reset", {res_valid, res_hit, match_out, res_index}, 72'h0);
        rd_chk(2'd2, 4, 72'h0, "R1");

        // R12: lookup while disabled yields no result
        for (int j = 0; j < 64; j++) begin
            m_data[j] = '0;
            m_mask[j] = '0;
        end
        for (int g = 0; g < 4; g++) m_gm[g] = '0;
        keys = '0;
        lookup(keys, 1, 0, 1'b0, "R12");

        // load arrays and registers
        for (int e = 0; e < 64; e++) begin
            m_data[e] = {8'hA5, 58'h0, 6'(e)};
            m_mask[e] = (e == 63) ? {1'b0, {71{1'b1}}} : (e >= 32) ? 72'h3 : 72'h0;
            wr(2'd0, e, m_data[e]);
            wr(2'd1, e, m_mask[e]);
        end
        m_gm[0] = 72'h0;
        m_gm[1] = 72'h10;
        m_gm[2] = {8'hFF, 64'h0};
        m_gm[3] = 72'h3F;
        for (int g = 0; g < 4; g++) wr(2'd2, g, m_gm[g]);
        wr(2'd2, 4, 72'h1);

        // R2, R3 read-back
        rd_chk(2'd0, 5, m_data[5], "R2");
        rd_chk(2'd0, 63, m_data[63], "R2");
        rd_chk(2'd1, 40, m_mask[40], "R3");
        rd_chk(2'd1, 63, m_mask[63], "R3");
        rd_chk(2'd2, 2, m_gm[2], "R3");
        rd_chk(2'd2, 4, 72'h1, "R3");
        rd_chk(2'd2, 7, 72'h0, "R3");

        // R4 R5 R6 R8: back-to-back single-word sweep under every global mask
        for (int gs = 0; gs < 4; gs++) begin
            for (int k = 0; k < 64; k++) begin
                keys = '0;
                keys[0] = mk_key((k % 3 == 0) ? 8'h5A : 8'hA5, k);
                ref_lookup(keys, 1, gs, p_hit[k], p_idx[k]);
            end
            for (int i = 0; i < 66; i++) begin
                @(posedge clk); #1;
                if (i < 64) begin
                    req_strobe = 1'b1; cmd_op = 2'd3; cmd_gsel = 2'(gs); tb_oe = 1'b1;
                    tb_bus = mk_key((i % 3 == 0) ? 8'h5A : 8'hA5, i);
                end else begin
                    idle_inputs();
                end
                @(negedge clk);
                if (i >= 2) begin
                    string rq;
                    rq = (gs == 0) ? "R4/R6/R8" : "R5/R8";
                    chk(res_valid == 1'b1, rq, "res_valid", 72'(res_valid), 72'h1);
                    chk(res_hit == p_hit[i-2], rq, "res_hit", 72'(res_hit), 72'(p_hit[i-2]));
                    chk(res_index == (p_hit[i-2] ? p_idx[i-2] : 6'd0), rq, "res_index",
                        72'(res_index), 72'(p_hit[i-2] ? p_idx[i-2] : 6'd0));
                end
            end
        end

        // R7: plain miss
        keys = '0;
        keys[0] = mk_key(8'h00, 1);
        lookup(keys, 1, 0, 1'b1, "R7");

        // R11: cascade suppression on hit and on miss
        match_in = 1'b1;
        keys[0] = mk_key(8'hA5, 5);
        lookup(keys, 1, 0, 1'b1, "R11");
        keys[0] = mk_key(8'h00, 1);
        lookup(keys, 1, 0, 1'b1, "R11");
        match_in = 1'b0;

        // R9: two-word lookups
        wr(2'd2, 4, 72'h3);
        rd_chk(2'd2, 4, 72'h3, "R3");
        for (int k = 0; k < 64; k++) begin
            keys = '0;
            keys[0] = mk_key(8'hA5, k);
            keys[1] = mk_key(8'hA5, k ^ 1);
            lookup(keys, 2, 0, 1'b1, "R9");
        end

        // R10: four-word lookups
        wr(2'd2, 4, 72'h5);
        for (int k = 0; k < 64; k += 2) begin
            for (int j = 0; j < 4; j++) keys[j] = mk_key(8'hA5, (k + j) % 64);
            lookup(keys, 4, (k / 2) % 4, 1'b1, "R10");
        end

        // R12: disable again
        wr(2'd2, 4, 72'h0);
        keys = '0;
        keys[0] = mk_key(8'hA5, 3);
        lookup(keys, 1, 0, 1'b0, "R12");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule